// File: doc/BRIEF.md
# Packed Vector Compare and Bitwise Merge

This block compares two packed vectors lane by lane and turns each lane's outcome into a mask lane. A lane that passes the test becomes all ones and a lane that fails becomes all zeros. A three-bit predicate selects the test. Two of the eight codes ignore the operands and return a constant mask. The lane width can be 8, 16, 32 or 64 bits, and each width can be read as unsigned or as two's-complement signed.

A second stage merges two further vectors bit by bit under a selector. The selector is normally the compare mask, which gives a vector "cond ? x : y" in one pass. A separate mask input can also drive the selector, so the merge works on its own. Both the mask and the merged vector are captured in the same output register. A valid strobe follows the input strobe by one clock cycle.

Top module: `packed_cmp_select`

## Requirements
- R1: With predicate codes 000, 001, 010, 011, 100 and 101, a lane's result is true when a<b, a<=b, a>b, a>=b, a==b and a!=b respectively, where a is the `cmp_a` lane and b is the `cmp_b` lane.
- R2: Predicate 110 gives an all-zero mask and predicate 111 gives an all-ones mask, whatever the operands are.
- R3: `elem_size` 00, 01, 10 and 11 select lanes of 8, 16, 32 and 64 bits. Lane i occupies bits [i*W +: W] of every vector.
- R4: When `is_signed` is 0, lanes are ordered as unsigned magnitudes.
- R5: When `is_signed` is 1, lanes are ordered as two's-complement numbers of the selected lane width.
- R6: Every lane of `mask_out` is either all ones (true) or all zeros (false).
- R7: Each bit of `merged_out` equals the matching bit of `sel_x` where the selector bit is 1, and the bit of `sel_y` where it is 0.
- R8: When `use_ext_mask` is 0, the selector is the compare mask. When it is 1, the selector is `ext_mask`. In both cases `mask_out` still reports the compare mask.
- R9: `mask_out` and `merged_out` are registered together when `in_valid` is 1. `out_valid` equals `in_valid` delayed by one clock. While `in_valid` is 0, both data outputs hold their values.
- R10: During reset, `out_valid`, `mask_out` and `merged_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe; captures the results |
| cmp_a | input | VEC_W | First compare operand |
| cmp_b | input | VEC_W | Second compare operand |
| pred | input | 3 | Predicate code |
| elem_size | input | 2 | Lane width code |
| is_signed | input | 1 | 1 = signed ordering |
| use_ext_mask | input | 1 | 1 = merge under ext_mask |
| ext_mask | input | VEC_W | External selector |
| sel_x | input | VEC_W | Merge source taken on selector 1 |
| sel_y | input | VEC_W | Merge source taken on selector 0 |
| out_valid | output | 1 | Result strobe |
| mask_out | output | VEC_W | Registered compare mask |
| merged_out | output | VEC_W | Registered merged vector |

## Verification
The hardest cases to reach are lane boundaries where the signed and unsigned orderings disagree: the sign bit set in one lane and clear in its neighbour. At 64-bit width the top lane bit is also the top bit of the word, so an extension error shows up only there. Purely random data seldom lines up equal lanes, or the lane minimum against the lane maximum, at every width. The stimulus therefore fills each lane from a rotating set of edge values (zero, one, all ones, the signed minimum and the signed maximum) mixed with random values, and forces equal lanes at regular positions. It runs this set for every width, every signedness and every predicate.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   typedef enum logic [2:0] {
      PR_LT     = 3'b000,
      PR_LE     = 3'b001,
      PR_GT     = 3'b010,
      PR_GE     = 3'b011,
      PR_EQ     = 3'b100,
      PR_NE     = 3'b101,
      PR_NEVER  = 3'b110,
      PR_ALWAYS = 3'b111
   } pcs_pred_e;

   typedef enum logic [1:0] {
      EW_8  = 2'b00,
      EW_16 = 2'b01,
      EW_32 = 2'b10,
      EW_64 = 2'b11
   } pcs_width_e;

   localparam int unsigned PCS_MIN_LANE_W = 8;
   localparam int unsigned PCS_MAX_WIDTHS = 4;

   // Turn the two primitive relations of one lane into the predicate outcome.
   function automatic logic pcs_pred_eval(input pcs_pred_e p, input logic lt, input logic eq);
      logic r;
      unique case (p)
         PR_LT:     r = lt;
         PR_LE:     r = lt | eq;
         PR_GT:     r = ~(lt | eq);
         PR_GE:     r = ~lt;
         PR_EQ:     r = eq;
         PR_NE:     r = ~eq;
         PR_NEVER:  r = 1'b0;
         default:   r = 1'b1;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/pcs_lane_bank.sv
module pcs_lane_bank
   import pcs_pkg::*;
#(
   parameter int unsigned VEC_W  = 128,
   parameter int unsigned LANE_W = 8
) (
   input  logic [VEC_W-1:0] op_a,
   input  logic [VEC_W-1:0] op_b,
   input  pcs_pred_e        pred,
   input  logic             is_signed,
   output logic [VEC_W-1:0] lane_mask
);

   localparam int unsigned LANES = VEC_W / LANE_W;
   localparam int unsigned EXT_W = LANE_W + 1;

   if (LANE_W < PCS_MIN_LANE_W || (VEC_W % LANE_W) != 0) begin : g_bad_cfg
      $error("pcs_lane_bank: lane width must be >= 8 and divide VEC_W");
   end

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_W-1:0] va, vb;
      logic [EXT_W-1:0]  xa, xb;
      logic              lt, eq, hit;

      assign va = op_a[l*LANE_W +: LANE_W];
      assign vb = op_b[l*LANE_W +: LANE_W];
      // One extra bit: sign copy in signed mode, zero in unsigned mode.
      assign xa = {is_signed & va[LANE_W-1], va};
      assign xb = {is_signed & vb[LANE_W-1], vb};
      assign lt = $signed(xa) < $signed(xb);
      assign eq = (va == vb);
      assign hit = pcs_pred_eval(pred, lt, eq);
      assign lane_mask[l*LANE_W +: LANE_W] = {LANE_W{hit}};

      // R1: strict ordering and equality are mutually exclusive
      always_comb begin
         a_r1_lt_excludes_eq: assert (!(lt && eq))
            else $error("lane reports both less-than and equal");
      end
   end

endmodule

// File: rtl/pcs_width_mux.sv
module pcs_width_mux
   import pcs_pkg::*;
#(
   parameter int unsigned VEC_W      = 128,
   parameter int unsigned NUM_WIDTHS = 4
) (
   input  logic [NUM_WIDTHS-1:0][VEC_W-1:0] bank_mask,
   input  logic [1:0]                       size_code,
   output logic [VEC_W-1:0]                 mask
);

   if (NUM_WIDTHS < 1 || NUM_WIDTHS > PCS_MAX_WIDTHS) begin : g_bad_cfg
      $error("pcs_width_mux: NUM_WIDTHS out of range");
   end

   // Padded to the full code space; codes without a bank produce zero.
   logic [PCS_MAX_WIDTHS-1:0][VEC_W-1:0] padded;

   for (genvar w = 0; w < PCS_MAX_WIDTHS; w++) begin : g_pad
      if (w < NUM_WIDTHS) begin : g_have
         assign padded[w] = bank_mask[w];
      end else begin : g_none
         assign padded[w] = '0;
      end
   end

   assign mask = padded[size_code];

endmodule

// File: rtl/pcs_bit_merge.sv
module pcs_bit_merge #(
   parameter int unsigned VEC_W   = 128,
   parameter int unsigned SLICE_W = 32
) (
   input  logic [VEC_W-1:0] sel,
   input  logic [VEC_W-1:0] src_x,
   input  logic [VEC_W-1:0] src_y,
   output logic [VEC_W-1:0] merged
);

   localparam int unsigned SLICES = VEC_W / SLICE_W;

   if (SLICE_W == 0 || (VEC_W % SLICE_W) != 0) begin : g_bad_cfg
      $error("pcs_bit_merge: SLICE_W must divide VEC_W");
   end

   for (genvar s = 0; s < SLICES; s++) begin : g_slice
      logic [SLICE_W-1:0] m, x, y, o;
      assign m = sel[s*SLICE_W +: SLICE_W];
      assign x = src_x[s*SLICE_W +: SLICE_W];
      assign y = src_y[s*SLICE_W +: SLICE_W];
      assign o = (m & x) | (~m & y);
      assign merged[s*SLICE_W +: SLICE_W] = o;

      // R7: when both sources agree the selector is irrelevant
      always_comb begin
         a_r7_agree_passes: assert ((x != y) || (o == x))
            else $error("merge altered bits where both sources agree");
      end
   end

endmodule

// File: rtl/packed_cmp_select.sv
module packed_cmp_select
   import pcs_pkg::*;
#(
   parameter int unsigned VEC_W      = 128,
   parameter int unsigned MAX_LANE_W = 64,
   parameter int unsigned MERGE_SLICE = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [VEC_W-1:0] cmp_a,
   input  logic [VEC_W-1:0] cmp_b,
   input  logic [2:0]       pred,
   input  logic [1:0]       elem_size,
   input  logic             is_signed,
   input  logic             use_ext_mask,
   input  logic [VEC_W-1:0] ext_mask,
   input  logic [VEC_W-1:0] sel_x,
   input  logic [VEC_W-1:0] sel_y,
   output logic             out_valid,
   output logic [VEC_W-1:0] mask_out,
   output logic [VEC_W-1:0] merged_out
);

   localparam int unsigned NUM_WIDTHS = $clog2(MAX_LANE_W / PCS_MIN_LANE_W) + 1;

   if ((MAX_LANE_W & (MAX_LANE_W - 1)) != 0 || MAX_LANE_W < PCS_MIN_LANE_W
       || MAX_LANE_W > 64) begin : g_bad_lane
      $error("packed_cmp_select: MAX_LANE_W must be a power of two in 8..64");
   end
   if ((VEC_W % MAX_LANE_W) != 0) begin : g_bad_vec
      $error("packed_cmp_select: VEC_W must be a multiple of MAX_LANE_W");
   end

   pcs_pred_e pred_e;
   assign pred_e = pcs_pred_e'(pred);

   logic [NUM_WIDTHS-1:0][VEC_W-1:0] bank_mask;

   for (genvar w = 0; w < NUM_WIDTHS; w++) begin : g_bank
      pcs_lane_bank #(
         .VEC_W  (VEC_W),
         .LANE_W (PCS_MIN_LANE_W << w)
      ) u_bank (
         .op_a      (cmp_a),
         .op_b      (cmp_b),
         .pred      (pred_e),
         .is_signed (is_signed),
         .lane_mask (bank_mask[w])
      );
   end

   logic [VEC_W-1:0] cmp_mask;

   pcs_width_mux #(
      .VEC_W      (VEC_W),
      .NUM_WIDTHS (NUM_WIDTHS)
   ) u_wmux (
      .bank_mask (bank_mask),
      .size_code (elem_size),
      .mask      (cmp_mask)
   );

   logic [VEC_W-1:0] merge_sel;
   logic [VEC_W-1:0] merged;

   assign merge_sel = use_ext_mask ? ext_mask : cmp_mask;

   pcs_bit_merge #(
      .VEC_W   (VEC_W),
      .SLICE_W (MERGE_SLICE)
   ) u_merge (
      .sel    (merge_sel),
      .src_x  (sel_x),
      .src_y  (sel_y),
      .merged (merged)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid  <= 1'b0;
         mask_out   <= '0;
         merged_out <= '0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            mask_out   <= cmp_mask;
            merged_out <= merged;
         end
      end
   end

   // R9: strobe delay and hold behaviour
   a_r9_valid_delay: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (out_valid == $past(in_valid)));
   a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(mask_out) && $stable(merged_out)));

   // R2: constant predicates
   a_r2_never_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pred == PR_NEVER) |=> (mask_out == '0));
   a_r2_always_ones: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pred == PR_ALWAYS) |=> (mask_out == '1));

   // R1: equal operands satisfy the equality predicate in every lane
   a_r1_eq_self: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && pred == PR_EQ && cmp_a == cmp_b) |=> (mask_out == '1));

   // R8: selector source choice seen at the merged output
   a_r8_cmp_path: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !use_ext_mask && pred == PR_ALWAYS) |=> (merged_out == $past(sel_x)));
   a_r8_ext_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && use_ext_mask && ext_mask == '0) |=> (merged_out == $past(sel_y)));

endmodule

// File: tb/sim_packed_cmp_select.sv
`timescale 1ns/1ps
module sim_packed_cmp_select;

   localparam int VW = 128;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [VW-1:0] cmp_a = '0, cmp_b = '0, ext_mask = '0, sel_x = '0, sel_y = '0;
   logic [2:0]    pred = '0;
   logic [1:0]    elem_size = '0;
   logic          is_signed = 1'b0, use_ext_mask = 1'b0;
   logic          out_valid;
   logic [VW-1:0] mask_out, merged_out;

   int total = 0;
   int bad = 0;
   logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

   always #2 clk = ~clk;

   packed_cmp_select u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .cmp_a(cmp_a), .cmp_b(cmp_b), .pred(pred), .elem_size(elem_size),
      .is_signed(is_signed), .use_ext_mask(use_ext_mask), .ext_mask(ext_mask),
      .sel_x(sel_x), .sel_y(sel_y), .out_valid(out_valid),
      .mask_out(mask_out), .merged_out(merged_out)
   );

   function automatic logic [63:0] next_rnd(input logic [63:0] s);
      logic [63:0] t = s;
      t = t ^ (t << 13);
      t = t ^ (t >> 7);
      t = t ^ (t << 17);
      return t;
   endfunction

   function automatic logic [63:0] edge_val(input int kind, input int w, input logic [63:0] r);
      logic [63:0] m = (w == 64) ? '1 : ((64'd1 << w) - 64'd1);
      case (kind % 6)
         0: return 64'd0;
         1: return 64'd1;
         2: return m;
         3: return 64'd1 << (w - 1);
         4: return m >> 1;
         default: return r & m;
      endcase
   endfunction

   function automatic logic [VW-1:0] model_mask(input logic [VW-1:0] a, input logic [VW-1:0] b,
                                                input int p, input int sz, input bit sg);
      int w = 8 << sz;
      logic [VW-1:0] r = '0;
      for (int i = 0; i < VW / w; i++) begin
         logic [63:0] av = '0;
         logic [63:0] bv = '0;
         logic signed [65:0] ea, eb;
         bit t;
         for (int j = 0; j < w; j++) begin
            av[j] = a[i*w + j];
            bv[j] = b[i*w + j];
         end
         ea = $signed({2'b00, av});
         eb = $signed({2'b00, bv});
         if (sg && av[w-1]) ea = ea - (66'sd1 <<< w);
         if (sg && bv[w-1]) eb = eb - (66'sd1 <<< w);
         case (p)
            0: t = ea < eb;
            1: t = ea <= eb;
            2: t = ea > eb;
            3: t = ea >= eb;
            4: t = ea == eb;
            5: t = ea != eb;
            6: t = 1'b0;
            default: t = 1'b1;
         endcase
         for (int j = 0; j < w; j++) r[i*w + j] = t;
      end
      return r;
   endfunction

   task automatic check(input string tag, input logic [VW-1:0] act, input logic [VW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   initial begin
      #800000;
      bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      // R10: reset state
      @(negedge clk);
      check("R10 out_valid", {127'd0, out_valid}, '0);
      check("R10 mask_out", mask_out, '0);
      check("R10 merged_out", merged_out, '0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int sz = 0; sz < 4; sz++) begin
         for (int sg = 0; sg < 2; sg++) begin
            for (int p = 0; p < 8; p++) begin
               for (int k = 0; k < 24; k++) begin
                  int w = 8 << sz;
                  logic [VW-1:0] a = '0;
                  logic [VW-1:0] b = '0;
                  logic [VW-1:0] em, sel, exp_m, exp_o;
                  string tg;
                  for (int i = 0; i < VW / w; i++) begin
                     logic [63:0] va, vb;
                     rng = next_rnd(rng);
                     va = edge_val(i + k, w, rng);
                     rng = next_rnd(rng);
                     vb = edge_val(i * 3 + k / 2 + 1, w, rng);
                     if (((i + k) % 4) == 0) vb = va;
                     for (int j = 0; j < w; j++) begin
                        a[i*w + j] = va[j];
                        b[i*w + j] = vb[j];
                     end
                  end
                  rng = next_rnd(rng); em = {rng, next_rnd(rng)};
                  rng = next_rnd(rng); sel_x = {rng, ~rng};
                  rng = next_rnd(rng); sel_y = {~rng, rng};
                  cmp_a = a; cmp_b = b; ext_mask = em;
                  pred = 3'(p); elem_size = 2'(sz); is_signed = sg[0];
                  use_ext_mask = k[0];
                  in_valid = 1'b1;
                  exp_m = model_mask(a, b, p, sz, sg[0]);
                  sel = k[0] ? em : exp_m;
                  exp_o = (sel & sel_x) | (~sel & sel_y);
                  @(negedge clk);
                  if (p >= 6) tg = "R2/R6";
                  else if (sg != 0) tg = "R1/R3/R5/R6";
                  else tg = "R1/R3/R4/R6";
                  check(tg, mask_out, exp_m);
                  check(k[0] ? "R7/R8 ext" : "R7/R8 cmp", merged_out, exp_o);
                  check("R9 valid", {127'd0, out_valid}, {127'd0, 1'b1});
               end
            end
         end
      end

      // R9: idle cycles hold the data outputs
      begin
         logic [VW-1:0] hm, ho;
         hm = mask_out; ho = merged_out;
         in_valid = 1'b0;
         cmp_a = ~cmp_a; pred = 3'b111; sel_x = ~sel_x; sel_y = ~sel_y;
         @(negedge clk);
         check("R9 strobe low", {127'd0, out_valid}, '0);
         @(negedge clk);
         check("R9 mask hold", mask_out, hm);
         check("R9 merged hold", merged_out, ho);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule